// File: doc/BRIEF.md
# Successive-Approximation ADC Controller

This block is the digital half of a 10-bit successive-approximation converter in a small microcontroller peripheral. Software programs a channel register and a mode register through a narrow 4-bit write port, then pulses `start`. The block drives a one-hot channel select to the analog multiplexer and a 10-bit code to an external DAC, and samples a single comparator bit once per clock. It resolves the code from MSB to LSB, keeps the result, and raises a completion flag.

The completion flag can raise an interrupt request or can simply be polled with a skip test. Either an interrupt acknowledge or a skip test that finds the flag set clears it. Setting the top bit of the mode register selects comparator mode. In that mode a start makes one comparison against a code preloaded through the write port, and the result register then holds the comparator bit. The result is read as an 8-bit upper part and a 2-bit lower part, with the lower part placed in the top two bits of a 4-bit word.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset both control registers read 0000, the result reads zero, and `busy`, `flag` and `irq_req` are 0.
- R2: A write to address 0 stores all four bits in the channel register (bit 3 is kept but has no effect). `ch_sel` is one-hot, with bit k high when bits 2..0 of that register equal k.
- R3: A write to address 1 stores all four bits in the mode register. Bits 2..0 appear on `pin_ana` (bit 2 = channels 7/6, bit 1 = channel 5, bit 0 = channel 4). Bit 3 = 0 selects conversion mode and bit 3 = 1 selects comparator mode.
- R4: In conversion mode, a start sampled at a clock edge makes `busy` high for exactly 11 cycles: 10 compare cycles and one latch cycle. `flag` rises at the edge where `busy` falls. The result is the largest code n for which the comparator reports that the input is at or above the DAC level n·VDD/1024.
- R5: The first trial code after a conversion start is 1000000000b. Each trial bit is kept when `cmp_in` is 1 and cleared when it is 0, from bit 9 down to bit 0.
- R6: A start that arrives while `busy` is high is ignored. The running conversion ends at its original time with its original result.
- R7: `res_hi` is result bits 9..2 and `res_lo` is {result bits 1..0, 00}. While a conversion runs they show the partially built code, and reading them has no effect on the conversion.
- R8: `irq_req` equals `flag` when `int_en` is 1 and is 0 otherwise. `irq_ack` clears `flag`.
- R9: `skip` is high in a cycle where `skip_test` is high and `flag` is set, and `flag` is then cleared. A `skip_test` that finds `flag` clear gives no skip.
- R10: When a completion and a clear request (acknowledge or skip test) fall in the same cycle, the flag ends up set.
- R11: In comparator mode, a start makes `busy` high for 2 cycles. During the first cycle `dac_code` equals the preloaded code. The result then holds the comparator bit in bit 0 and zero in every other bit, and `flag` rises as `busy` falls.
- R12: The preload code is written in 4-bit pieces: address 2 sets bits 3..0, address 3 sets bits 7..4, and address 4 sets bits 9..8 from data bits 1..0. While the block is idle, `dac_code` shows the preloaded code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 channel, 1 mode, 2..4 preload) |
| wr_data | input | 4 | Write data |
| start | input | 1 | Start strobe |
| cmp_in | input | 1 | Comparator output, 1 when input is at or above DAC level |
| int_en | input | 1 | 1 routes completion to `irq_req`, 0 leaves it to polling |
| irq_ack | input | 1 | Interrupt taken; clears the flag |
| skip_test | input | 1 | Skip-on-flag test |
| chan_q | output | 4 | Channel register readback |
| mode_q | output | 4 | Mode register readback |
| ch_sel | output | 8 | One-hot analog channel select |
| pin_ana | output | 3 | Analog function enables for pins of channels 7/6, 5, 4 |
| dac_code | output | 10 | Code to external DAC |
| busy | output | 1 | Conversion or compare in progress |
| res_hi | output | 8 | Result bits 9..2 |
| res_lo | output | 4 | Result bits 1..0 in bits 3..2, zeros below |
| flag | output | 1 | Completion flag |
| irq_req | output | 1 | Interrupt request |
| skip | output | 1 | Skip taken by the current skip test |

## Verification
Two events can land in the same cycle: the latch cycle that sets the completion flag, and a clear request from an interrupt acknowledge or a skip test. The bench counts cycles from the start strobe and drives `irq_ack`, or `skip_test`, during exactly the latch cycle. It then judges from the ports after that edge that `flag` is set. For the skip test it also checks that `skip` stayed low, because the flag was still clear when the test was made.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_CMP  = 2'd2,
    ST_DONE = 2'd3
  } sar_state_t;

  localparam logic [2:0] A_CHAN = 3'd0;
  localparam logic [2:0] A_MODE = 3'd1;
  localparam logic [2:0] A_LVL0 = 3'd2;
endpackage

// File: rtl/sar_regs.sv
module sar_regs #(
  parameter int CTL_W = 4,
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CTL_W-1:0] wr_data,
  output logic [CTL_W-1:0] chan_q,
  output logic [CTL_W-1:0] mode_q,
  output logic [RES_W-1:0] cmp_lvl
);
  import sar_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q  <= '0;
      mode_q  <= '0;
      cmp_lvl <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_CHAN) chan_q <= wr_data;
      if (wr_addr == A_MODE) mode_q <= wr_data;
      for (int b = 0; b < RES_W; b++) begin
        if (int'(wr_addr) == int'(A_LVL0) + b / CTL_W)
          cmp_lvl[b] <= wr_data[b % CTL_W];
      end
    end
  end
endmodule

// File: rtl/sar_engine.sv
module sar_engine #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cmp_mode,
  input  logic             cmp_in,
  input  logic [RES_W-1:0] cmp_lvl,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] dac_code,
  output logic [RES_W-1:0] result
);
  import sar_pkg::*;

  localparam int IDX_W = $clog2(RES_W);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(RES_W - 1);
  localparam logic [IDX_W-1:0] ONE     = IDX_W'(1);

  sar_state_t       state;
  logic [RES_W-1:0] sar;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      sar   <= '0;
      idx   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          if (cmp_mode) begin
            state <= ST_CMP;
          end else begin
            sar   <= {1'b1, {(RES_W-1){1'b0}}};
            idx   <= TOP_IDX;
            state <= ST_CONV;
          end
        end
        ST_CONV: begin
          if (!cmp_in) sar[idx] <= 1'b0;
          if (idx == '0) begin
            state <= ST_DONE;
          end else begin
            sar[idx - ONE] <= 1'b1;
            idx            <= idx - ONE;
          end
        end
        ST_CMP: begin
          sar   <= {{(RES_W-1){1'b0}}, cmp_in};
          state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_DONE);
  assign dac_code = (state == ST_CONV) ? sar : cmp_lvl;
  assign result   = sar;
endmodule

// File: rtl/sar_flag.sv
module sar_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic irq_ack,
  input  logic skip_test,
  input  logic int_en,
  output logic flag,
  output logic irq_req,
  output logic skip
);
  logic clr;

  assign skip = skip_test & flag;
  assign clr  = irq_ack | skip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  assign irq_req = flag & int_en;
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int CTL_W = 4,
  parameter int RES_W = 10,
  parameter int CH_N  = 8,
  parameter int LO_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [2:0]         wr_addr,
  input  logic [CTL_W-1:0]   wr_data,
  input  logic               start,
  input  logic               cmp_in,
  input  logic               int_en,
  input  logic               irq_ack,
  input  logic               skip_test,
  output logic [CTL_W-1:0]   chan_q,
  output logic [CTL_W-1:0]   mode_q,
  output logic [CH_N-1:0]    ch_sel,
  output logic [CTL_W-2:0]   pin_ana,
  output logic [RES_W-1:0]   dac_code,
  output logic               busy,
  output logic [RES_W-LO_W-1:0] res_hi,
  output logic [CTL_W-1:0]   res_lo,
  output logic               flag,
  output logic               irq_req,
  output logic               skip
);
  localparam int CH_W = $clog2(CH_N);

  logic [RES_W-1:0] cmp_lvl;
  logic [RES_W-1:0] result;
  logic             eng_done;

  sar_regs #(.CTL_W(CTL_W), .RES_W(RES_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .chan_q(chan_q), .mode_q(mode_q), .cmp_lvl(cmp_lvl)
  );

  sar_engine #(.RES_W(RES_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp_mode(mode_q[CTL_W-1]),
    .cmp_in(cmp_in), .cmp_lvl(cmp_lvl), .busy(busy), .done(eng_done),
    .dac_code(dac_code), .result(result)
  );

  sar_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set(eng_done), .irq_ack(irq_ack),
    .skip_test(skip_test), .int_en(int_en), .flag(flag),
    .irq_req(irq_req), .skip(skip)
  );

  for (genvar g = 0; g < CH_N; g++) begin : g_chsel
    assign ch_sel[g] = (chan_q[CH_W-1:0] == CH_W'(g));
  end

  assign pin_ana = mode_q[CTL_W-2:0];
  assign res_hi  = result[RES_W-1:LO_W];
  assign res_lo  = {result[LO_W-1:0], {(CTL_W-LO_W){1'b0}}};
endmodule

// File: rtl/sar_adc_chk.sv
module sar_adc_chk #(
  parameter int CTL_W = 4,
  parameter int RES_W = 10,
  parameter int CH_N  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             flag,
  input logic             irq_ack,
  input logic             skip,
  input logic             eng_done,
  input logic [CTL_W-1:0] mode_q,
  input logic [RES_W-1:0] dac_code,
  input logic [CH_N-1:0]  ch_sel
);
  assert_chsel_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ch_sel) == 1);

  assert_flag_after_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> (!busy && $past(eng_done)));

  assert_first_trial_msb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !mode_q[CTL_W-1]) |-> dac_code == {1'b1, {(RES_W-1){1'b0}}});

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && irq_ack && !eng_done) |=> !flag);

  assert_skip_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (skip && !eng_done) |=> !flag);

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> flag);

  assert_cmp_two_cycles_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && mode_q[CTL_W-1]) |=> (busy ##1 !busy));
endmodule

bind sar_adc_ctrl sar_adc_chk #(.CTL_W(CTL_W), .RES_W(RES_W), .CH_N(CH_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .flag(flag), .irq_ack(irq_ack),
  .skip(skip), .eng_done(eng_done), .mode_q(mode_q), .dac_code(dac_code),
  .ch_sel(ch_sel)
);

// File: tb/tb_sar_adc_ctrl.sv
`timescale 1ns/1ps
module tb_sar_adc_ctrl;
  logic       clk = 0, rst_n = 0;
  logic       wr_en = 0, start = 0, int_en = 0, irq_ack = 0, skip_test = 0;
  logic [2:0] wr_addr = 0;
  logic [3:0] wr_data = 0;
  logic       cmp_in;
  logic [3:0] chan_q, mode_q, res_lo;
  logic [7:0] ch_sel, res_hi;
  logic [2:0] pin_ana;
  logic [9:0] dac_code;
  logic       busy, flag, irq_req, skip;
  int         vin = 0;
  int         n_run = 0, n_fail = 0;

  always #5 clk = ~clk;
  assign cmp_in = (vin >= int'(dac_code));

  sar_adc_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start(start), .cmp_in(cmp_in), .int_en(int_en), .irq_ack(irq_ack),
    .skip_test(skip_test), .chan_q(chan_q), .mode_q(mode_q), .ch_sel(ch_sel),
    .pin_ana(pin_ana), .dac_code(dac_code), .busy(busy), .res_hi(res_hi),
    .res_lo(res_lo), .flag(flag), .irq_req(irq_req), .skip(skip)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int res_val();
    return (int'(res_hi) << 2) | int'(res_lo[3:2]);
  endfunction

  task automatic wr(input logic [2:0] a, input logic [3:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic clear_flag();
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0;
  endtask

  // full conversion with timing checks; second_start injects a start while busy
  task automatic conv(input int v, input bit second_start);
    vin = v;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(busy == 1, "R4", busy, 1);
    chk(dac_code == 10'h200, "R5", dac_code, 512);
    for (int c = 0; c < 10; c++) begin
      if (second_start && c == 3) start = 1;
      @(negedge clk);
      start = 0;
    end
    chk(busy == 1 && flag == 0, "R4", {busy, flag}, 2);
    @(negedge clk);
    chk(busy == 0 && flag == 1, second_start ? "R6" : "R4", {busy, flag}, 1);
    chk(res_val() == v, second_start ? "R6" : "R4", res_val(), v);
    chk(res_lo[1:0] == 2'b00 && res_hi == v[9:2], "R7", res_lo, (v & 3) << 2);
  endtask

  initial begin
    #(200000 * 10);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hang expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(chan_q == 0 && mode_q == 0, "R1", {chan_q, mode_q}, 0);
    chk(res_hi == 0 && res_lo == 0, "R1", {res_hi, res_lo}, 0);
    chk(busy == 0 && flag == 0 && irq_req == 0, "R1", {busy, flag, irq_req}, 0);

    for (int c = 0; c < 16; c++) begin
      wr(3'd0, 4'(c));
      chk(chan_q == 4'(c), "R2", chan_q, c);
      chk(ch_sel == 8'(1 << (c % 8)), "R2", ch_sel, 1 << (c % 8));
    end
    for (int m = 0; m < 8; m++) begin
      wr(3'd1, 4'(m));
      chk(mode_q == 4'(m) && pin_ana == 3'(m), "R3", mode_q, m);
    end
    wr(3'd1, 4'd0);

    // exhaustive conversion sweep over all codes
    for (int v = 0; v < 1024; v++) begin
      conv(v, 0);
      clear_flag();
    end

    // start while busy is ignored
    conv(700, 1);
    clear_flag();

    // partial value visible mid-conversion, conversion unharmed
    vin = 1023;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    repeat (2) @(negedge clk);
    chk(res_hi[7:5] == 3'b111, "R7", res_hi, 224);
    repeat (9) @(negedge clk);
    chk(res_val() == 1023 && flag == 1, "R7", res_val(), 1023);

    // interrupt routing and acknowledge
    int_en = 1;
    #1 chk(irq_req == 1, "R8", irq_req, 1);
    int_en = 0;
    #1 chk(irq_req == 0, "R8", irq_req, 0);
    int_en = 1;
    clear_flag();
    chk(flag == 0 && irq_req == 0, "R8", flag, 0);
    int_en = 0;

    // skip test
    conv(5, 0);
    @(negedge clk); skip_test = 1;
    #1 chk(skip == 1, "R9", skip, 1);
    @(negedge clk); skip_test = 0;
    chk(flag == 0, "R9", flag, 0);
    skip_test = 1;
    #1 chk(skip == 0, "R9", skip, 0);
    @(negedge clk); skip_test = 0;

    // collision: ack in the latch cycle
    vin = 100;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    repeat (10) @(negedge clk);
    irq_ack = 1;
    @(negedge clk); irq_ack = 0;
    chk(flag == 1, "R10", flag, 1);
    clear_flag();
    // collision: skip test in the latch cycle
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    repeat (10) @(negedge clk);
    skip_test = 1;
    #1 chk(skip == 0, "R10", skip, 0);
    @(negedge clk); skip_test = 0;
    chk(flag == 1, "R10", flag, 1);
    clear_flag();

    // comparator mode with preload
    wr(3'd2, 4'hC); wr(3'd3, 4'h2); wr(3'd4, 4'h1);  // 0x12C = 300
    chk(dac_code == 10'd300, "R12", dac_code, 300);
    wr(3'd1, 4'h8);
    for (int k = 0; k < 4; k++) begin
      automatic int v = (k == 0) ? 300 : (k == 1) ? 299 : (k == 2) ? 1023 : 0;
      automatic int e = (v >= 300) ? 1 : 0;
      vin = v;
      @(negedge clk); start = 1;
      @(negedge clk); start = 0;
      chk(busy == 1 && dac_code == 10'd300, "R11", dac_code, 300);
      @(negedge clk);
      chk(busy == 1 && flag == 0, "R11", {busy, flag}, 2);
      @(negedge clk);
      chk(busy == 0 && flag == 1, "R11", {busy, flag}, 1);
      chk(res_val() == e, "R11", res_val(), e);
      clear_flag();
    end
    wr(3'd4, 4'h3);
    chk(dac_code == 10'h32C, "R12", dac_code, 'h32C);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule